// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of 32 general-purpose input pins and turns selected pin activity into a single interrupt request. Each line has its own trigger type: rising edge, falling edge, high level, low level, or either edge. A line takes part only when the pin-mux selection for that pin picks the interrupt function. A detected trigger sets a sticky pending bit. Software clears a pending bit by writing a one to it. The pending bits that are also enabled are combined into one registered interrupt line for the bank.

Pins are asynchronous to the clock, so each pin passes through a two-stage synchroniser before detection. Edges are found by comparing the synchronised value with its value one cycle earlier.

Configuration goes through a plain register port: a byte address, write data, a write strobe and combinational read data. Writes take effect at the clock edge on which the strobe is high. The port has no stream traffic and no back-pressure, so all of its pins are plain control and status signals. The debounce register only stores a value; it does not affect detection.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every trigger word, the enable word, the pending word and the debounce word read 0, and `irq_o` is low.
- R2: Address bits [4:2] select a word. Words 0 to 3 (byte offsets 0x00 to 0x0C) hold the trigger fields, with line n in word n/8 at bits (n%8)*4+3:(n%8)*4. Word 4 (0x10) is the enable word and word 5 (0x14) is the pending word, each with bit n for line n. Word 6 (0x18) holds a stored 32-bit debounce value. Word 7 reads 0, and writes to it change nothing.
- R3: A line can set its pending bit only while `mux_sel_i[4n+3:4n]` equals 6. Any other value, including 0 (plain input), blocks it.
- R4: Trigger code 0 sets the pending bit on a 0-to-1 change of the synchronised pin.
- R5: Trigger code 1 sets the pending bit on a 1-to-0 change of the synchronised pin.
- R6: Code 2 sets the pending bit while the synchronised pin is high, and code 3 while it is low. Clearing the bit while the level persists leaves it set.
- R7: Trigger code 4 sets the pending bit on a change of the synchronised pin in either direction.
- R8: Trigger codes 5 to 15 never set a pending bit.
- R9: A pending bit is set whether or not its line is enabled. Writing 1 to a bit of the pending word clears that bit. Writing 0 leaves the bit unchanged.
- R10: When a trigger and a clearing write for the same line land on the same clock edge, the pending bit ends up set.
- R11: `irq_o` is the OR over all lines of (pending AND enable), registered, so it follows the pending and enable words one clock later.
- R12: A pin change driven before clock edge A is seen in the pending word after edge A+2 and on `irq_o` after edge A+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Asynchronous pin levels, bit n is line n |
| mux_sel_i | input | 128 | Pin-mux selection, 4 bits per pin; value 6 selects the interrupt function |
| reg_addr_i | input | 5 | Register byte address; bits [4:2] select the word |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Bank interrupt request, registered |

## Verification
A trigger that sets a pending bit and a software write that clears the same bit can land on the same clock edge. The bench provokes this by raising a pin on a rising-edge line and timing the clearing write so that it reaches the clock edge on which the synchronised edge is latched. The bit must then read back as set. The same write issued one cycle later must leave the bit clear. A level-triggered line is also cleared while its level is held, and its bit must stay set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned LINES      = 32;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [3:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  localparam logic [3:0] MUX_IRQ_SEL = 4'd6;

  localparam logic [2:0] WIDX_EN   = 3'd4;
  localparam logic [2:0] WIDX_PEND = 3'd5;
  localparam logic [2:0] WIDX_DEB  = 3'd6;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned FW = 4
) (
  input  logic [N-1:0]    cur_i,
  input  logic [N-1:0]    prev_i,
  input  logic [N*FW-1:0] cfg_i,
  input  logic [N*FW-1:0] mux_i,
  output logic [N-1:0]    hit_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      logic [FW-1:0] code;
      logic [FW-1:0] sel;
      logic          raw;
      assign code = cfg_i[i*FW +: FW];
      assign sel  = mux_i[i*FW +: FW];

      always_comb begin
        case (code)
          TRIG_RISE: raw = cur_i[i] & ~prev_i[i];
          TRIG_FALL: raw = ~cur_i[i] & prev_i[i];
          TRIG_HIGH: raw = cur_i[i];
          TRIG_LOW:  raw = ~cur_i[i];
          TRIG_BOTH: raw = cur_i[i] ^ prev_i[i];
          default:   raw = 1'b0;
        endcase
      end

      assign hit_o[i] = raw & (sel == MUX_IRQ_SEL);

      always_comb begin
        // R3 R8
        if ((code > 4'd4) || (sel != MUX_IRQ_SEL)) begin
          gate_chk: assert (!hit_o[i]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned FW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [N-1:0]    hit_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N*FW-1:0] cfg_o,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    pend_o
);
  localparam int unsigned PER_WORD  = DW / FW;
  localparam int unsigned CFG_WORDS = N / PER_WORD;

  logic [N*FW-1:0] cfg_q;
  logic [N-1:0]    en_q;
  logic [N-1:0]    pend_q;
  logic [DW-1:0]   deb_q;
  logic [2:0]      widx;
  logic [N-1:0]    clr_w;

  assign widx  = addr_i[4:2];
  assign clr_w = (wr_i && widx == WIDX_PEND) ? wdata_i[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
      deb_q <= '0;
    end else if (wr_i) begin
      for (int k = 0; k < CFG_WORDS; k++) begin
        if (widx == 3'(k)) cfg_q[k*DW +: DW] <= wdata_i;
      end
      if (widx == WIDX_EN)  en_q  <= wdata_i[N-1:0];
      if (widx == WIDX_DEB) deb_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_w) | hit_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < CFG_WORDS; k++) begin
      if (widx == 3'(k)) rdata_o = cfg_q[k*DW +: DW];
    end
    case (widx)
      WIDX_EN:   rdata_o = DW'(en_q);
      WIDX_PEND: rdata_o = DW'(pend_q);
      WIDX_DEB:  rdata_o = deb_q;
      default:   ;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_w) != '0) |-> ((pend_q & $past(clr_w) & ~$past(hit_i)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(hit_i)) == $past(hit_i)));

  // R9
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]         pin_i,
  input  logic [LINES*FIELD_W-1:0] mux_sel_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_wr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic                     irq_o
);
  logic [LINES-1:0]         cur_w;
  logic [LINES-1:0]         prev_w;
  logic [LINES-1:0]         hit_w;
  logic [LINES*FIELD_W-1:0] cfg_w;
  logic [LINES-1:0]         en_w;
  logic [LINES-1:0]         pend_w;
  logic                     irq_q;

  gpio_irq_sync #(.W(LINES), .STAGES(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .cur_o(cur_w), .prev_o(prev_w)
  );

  gpio_irq_detect #(.N(LINES), .FW(FIELD_W)) i_detect (
    .cur_i(cur_w), .prev_i(prev_w), .cfg_i(cfg_w), .mux_i(mux_sel_i),
    .hit_o(hit_w)
  );

  gpio_irq_regs #(.N(LINES), .FW(FIELD_W), .DW(DATA_W), .AW(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .hit_i(hit_w), .rdata_o(reg_rdata_o),
    .cfg_o(cfg_w), .en_o(en_w), .pend_o(pend_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_w & en_w);
  end

  assign irq_o = irq_q;

  // R11
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|pend_w));

  // R11
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|en_w) |-> !irq_o);
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  pin = '0;
  logic [127:0] mux = '0;
  logic [4:0]   addr = '0;
  logic         wr = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mux_sel_i(mux),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [4:0] line;
    logic [3:0] code;
    logic [3:0] sel;
    logic       v0;
    logic       v1;
    logic       exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  4'd0, 4'd6, 1'b0, 1'b1, 1'b1},  // R4 rise
    '{5'd3,  4'd0, 4'd6, 1'b1, 1'b0, 1'b0},  // R4 fall ignored
    '{5'd9,  4'd1, 4'd6, 1'b1, 1'b0, 1'b1},  // R5
    '{5'd9,  4'd1, 4'd6, 1'b0, 1'b1, 1'b0},  // R5
    '{5'd17, 4'd4, 4'd6, 1'b0, 1'b1, 1'b1},  // R7
    '{5'd17, 4'd4, 4'd6, 1'b1, 1'b0, 1'b1},  // R7
    '{5'd20, 4'd5, 4'd6, 1'b0, 1'b1, 1'b0},  // R8
    '{5'd20, 4'd7, 4'd6, 1'b1, 1'b0, 1'b0},  // R8
    '{5'd31, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0},  // R3 mux input
    '{5'd31, 4'd0, 4'd6, 1'b0, 1'b1, 1'b1},  // R3 mux irq
    '{5'd0,  4'd2, 4'd6, 1'b0, 1'b1, 1'b1},  // R6 high
    '{5'd0,  4'd3, 4'd6, 1'b1, 1'b0, 1'b1}   // R6 low
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int w = 0; w < 7; w++) begin
      rreg(5'(w * 4), d);
      chk("R1 word after reset", d, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // R2 register map
    wreg(5'h00, 32'h1234_5678);
    wreg(5'h0C, 32'hCAFE_0042);
    wreg(5'h10, 32'h8000_0001);
    wreg(5'h18, 32'hDEAD_BEEF);
    wreg(5'h1C, 32'hFFFF_FFFF);
    rreg(5'h00, d); chk("R2 cfg word0", d, 32'h1234_5678);
    rreg(5'h0C, d); chk("R2 cfg word3", d, 32'hCAFE_0042);
    rreg(5'h10, d); chk("R2 enable", d, 32'h8000_0001);
    rreg(5'h18, d); chk("R2 debounce", d, 32'hDEAD_BEEF);
    rreg(5'h1C, d); chk("R2 unused word", d, 32'h0);
    rreg(5'h04, d); chk("R2 unused write no effect", d, 32'h0);
    wreg(5'h00, 32'h0); wreg(5'h0C, 32'h0); wreg(5'h10, 32'h0);
    repeat (4) @(negedge clk);
    wreg(5'h14, 32'hFFFF_FFFF);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [4:0] ca;
      v = VECS[i];
      ca = 5'((int'(v.line) / 8) * 4);
      mux = '0;
      mux[int'(v.line)*4 +: 4] = v.sel;
      wreg(ca, 32'(v.code) << ((int'(v.line) % 8) * 4));
      pin = 32'(v.v0) << v.line;
      repeat (4) @(negedge clk);
      wreg(5'h14, 32'hFFFF_FFFF);
      pin = 32'(v.v1) << v.line;
      repeat (4) @(negedge clk);
      rreg(5'h14, d);
      chk($sformatf("R3-8 vector %0d pending", i), d, 32'(v.exp) << v.line);
      mux = '0;
      wreg(ca, 32'h0);
      pin = '0;
      repeat (4) @(negedge clk);
      wreg(5'h14, 32'hFFFF_FFFF);
    end

    // R12 R11 latency: line 5 rising, enabled
    mux[5*4 +: 4] = 4'd6;
    wreg(5'h00, 32'h0);
    wreg(5'h10, 32'h0000_0020);
    repeat (2) @(negedge clk);
    addr = 5'h14;
    pin[5] = 1'b1;
    @(negedge clk); #1 chk("R12 pending after A", rdata, 32'h0);
    @(negedge clk); #1 chk("R12 pending after A+1", rdata, 32'h0);
    @(negedge clk); #1 chk("R12 pending after A+2", rdata, 32'h20);
    chk("R11 irq lags pending", 32'(irq), 32'h0);
    @(negedge clk); chk("R12 irq after A+3", 32'(irq), 32'h1);

    // R10 trigger and clear on the same edge
    pin[5] = 1'b0;
    repeat (4) @(negedge clk);
    wreg(5'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 irq drops after clear", 32'(irq), 32'h0);
    pin[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = 5'h14; wdata = 32'h20; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    #1 chk("R10 set wins over clear", rdata, 32'h20);
    wreg(5'h14, 32'h20);
    rreg(5'h14, d); chk("R10 later clear takes effect", d, 32'h0);

    // R9 enable gating and write-one-to-clear
    wreg(5'h10, 32'h0);
    pin[5] = 1'b0;
    repeat (4) @(negedge clk);
    pin[5] = 1'b1;
    repeat (5) @(negedge clk);
    rreg(5'h14, d); chk("R9 pending while disabled", d, 32'h20);
    chk("R9 irq low while disabled", 32'(irq), 32'h0);
    wreg(5'h14, 32'hFFFF_FFDF);
    rreg(5'h14, d); chk("R9 write zero keeps bit", d, 32'h20);
    wreg(5'h10, 32'h20);
    @(negedge clk); chk("R11 irq after enable", 32'(irq), 32'h1);
    wreg(5'h14, 32'h20);
    @(negedge clk); chk("R9 irq low after clear", 32'(irq), 32'h0);
    rreg(5'h14, d); chk("R9 bit cleared", d, 32'h0);

    // R6 level re-asserts after clear
    mux = '0; mux[0 +: 4] = 4'd6;
    wreg(5'h00, 32'h2);
    pin = 32'h1;
    repeat (4) @(negedge clk);
    wreg(5'h14, 32'h1);
    rreg(5'h14, d); chk("R6 high level re-sets", d, 32'h1);
    pin = '0;
    repeat (4) @(negedge clk);
    wreg(5'h14, 32'h1);
    rreg(5'h14, d); chk("R6 cleared once level gone", d, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule